// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a test-clock data-register chain through which an external debugger reads and writes a small bank of debug registers. The TAP controller outside the block drives the capture, shift and update strobes. The block acts on those strobes only when its chain is selected and the matching instruction is active. One scan moves a 38-bit word, least-significant bit first. The word holds a 32-bit data field, a 5-bit register address and a direction flag.

A write finishes within one scan. A read takes two scans. The first scan leaves the address behind at its update step. The second scan captures that register into the data field and shifts it out. The bank holds a debug control register, a read-only status view of the core, a vector-catch register, a communications control/data pair and two watchpoint units. Their contents drive output ports that a neighbouring comparator uses.

Top module: `dbg_scan_chain`

## Requirements
- R1: While `trst_n` is low, every register port, `mon_en`, `tdo` and the pending read address are zero, with no clock needed. The first capture after reset returns register 0.
- R2: On a TCK rising edge with shift strobed, the chain moves one place toward bit 0 and takes `tdi` into bit 37. `tdo` always shows bit 0, so the data field leaves least-significant bit first.
- R3: When update is strobed and bit 37 of the word is 1, bits 31:0 are written into the register selected by bits 36:32.
- R4: When update is strobed and bit 37 is 0, bits 36:32 become the pending read address. The next capture loads that register's value into bits 31:0 and clears bits 37:32.
- R5: The address map is: 0 = control (6 bits), 1 = status, 2 = vector catch (8 bits), 4 = comms control (6 bits), 5 = comms data (32 bits). Watchpoint unit 0 sits at 8 and unit 1 at 16. Each unit has these offsets: +0 address value, +1 address mask, +2 data value, +3 data mask (each 32 bits), +4 control value (9 bits), +5 control mask (8 bits).
- R6: Register bits above a register's width read as 0, and writes to them are dropped. Unmapped addresses read 0 and ignore writes. Status (address 1) reads the `core_status` input and ignores writes.
- R7: A read of comms control returns the `VERSION` parameter in bits 31:28.
- R8: `mon_en` follows bit 4 of the control register.
- R9: When `chain_sel` or `instr_active` is low, the strobes have no effect on the chain, the bank or the pending address.
- R10: A write leaves the pending read address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial data in |
| chain_sel | input | 1 | This chain is selected |
| instr_active | input | 1 | The access instruction is loaded |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| core_status | input | 5 | Status bits from the core |
| tdo | output | 1 | Serial data out |
| mon_en | output | 1 | Monitor-mode enable |
| dbg_ctrl | output | 6 | Control register |
| vec_catch | output | 8 | Vector-catch register |
| comms_ctrl | output | 6 | Comms control bits |
| comms_data | output | 32 | Comms data register |
| wp_addr_val | output | 2x32 | Address value per unit |
| wp_addr_msk | output | 2x32 | Address mask per unit |
| wp_data_val | output | 2x32 | Data value per unit |
| wp_data_msk | output | 2x32 | Data mask per unit |
| wp_ctl_val | output | 2x9 | Control value per unit |
| wp_ctl_msk | output | 2x8 | Control mask per unit |

## Verification
A pending read and a write can overlap. A read scan leaves an address pending, a write scan to another register follows, and the capture of the write scan must still return the register named by the earlier read. The bench provokes this by reading watchpoint address 8 and then writing the comms data register. It checks that the write scan shifts out the value of address 8 while the comms port takes the new data. A behavioural model of the chain is compared with `tdo` and every register port on each clock.

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
  parameter logic [3:0] VERSION = 4'd5
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             chain_sel,
  input  logic             instr_active,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic [4:0]       core_status,
  output logic             tdo,
  output logic             mon_en,
  output logic [5:0]       dbg_ctrl,
  output logic [7:0]       vec_catch,
  output logic [5:0]       comms_ctrl,
  output logic [31:0]      comms_data,
  output logic [1:0][31:0] wp_addr_val,
  output logic [1:0][31:0] wp_addr_msk,
  output logic [1:0][31:0] wp_data_val,
  output logic [1:0][31:0] wp_data_msk,
  output logic [1:0][8:0]  wp_ctl_val,
  output logic [1:0][7:0]  wp_ctl_msk
);
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int SW = DW + AW + 1;

  logic [SW-1:0] sr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rdata;

  wire          active = chain_sel & instr_active;
  wire          do_cap = active & capture_dr;
  wire          do_sh  = active & shift_dr & ~capture_dr;
  wire          do_up  = active & update_dr & ~capture_dr & ~shift_dr;
  wire          dir_wr = sr[SW-1];
  wire [AW-1:0] waddr  = sr[DW+AW-1:DW];
  wire [DW-1:0] wdat   = sr[DW-1:0];
  wire          do_wr  = do_up & dir_wr;

  assign tdo    = sr[0];
  assign mon_en = dbg_ctrl[4];

  always_comb begin
    rdata = '0;
    case (rd_addr)
      5'd0:          rdata = {26'd0, dbg_ctrl};
      5'd1:          rdata = {27'd0, core_status};
      5'd2:          rdata = {24'd0, vec_catch};
      5'd4:          rdata = {VERSION, 22'd0, comms_ctrl};
      5'd5:          rdata = comms_data;
      5'd8,  5'd16:  rdata = wp_addr_val[rd_addr[4]];
      5'd9,  5'd17:  rdata = wp_addr_msk[rd_addr[4]];
      5'd10, 5'd18:  rdata = wp_data_val[rd_addr[4]];
      5'd11, 5'd19:  rdata = wp_data_msk[rd_addr[4]];
      5'd12, 5'd20:  rdata = {23'd0, wp_ctl_val[rd_addr[4]]};
      5'd13, 5'd21:  rdata = {24'd0, wp_ctl_msk[rd_addr[4]]};
      default:       rdata = '0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr      <= '0;
      rd_addr <= '0;
    end else if (do_cap) begin
      sr <= {{(AW+1){1'b0}}, rdata};
    end else if (do_sh) begin
      sr <= {tdi, sr[SW-1:1]};
    end else if (do_up && !dir_wr) begin
      rd_addr <= waddr;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      dbg_ctrl    <= '0;
      vec_catch   <= '0;
      comms_ctrl  <= '0;
      comms_data  <= '0;
      wp_addr_val <= '0;
      wp_addr_msk <= '0;
      wp_data_val <= '0;
      wp_data_msk <= '0;
      wp_ctl_val  <= '0;
      wp_ctl_msk  <= '0;
    end else if (do_wr) begin
      case (waddr)
        5'd0:         dbg_ctrl   <= wdat[5:0];
        5'd2:         vec_catch  <= wdat[7:0];
        5'd4:         comms_ctrl <= wdat[5:0];
        5'd5:         comms_data <= wdat;
        5'd8,  5'd16: wp_addr_val[waddr[4]] <= wdat;
        5'd9,  5'd17: wp_addr_msk[waddr[4]] <= wdat;
        5'd10, 5'd18: wp_data_val[waddr[4]] <= wdat;
        5'd11, 5'd19: wp_data_msk[waddr[4]] <= wdat;
        5'd12, 5'd20: wp_ctl_val[waddr[4]]  <= wdat[8:0];
        5'd13, 5'd21: wp_ctl_msk[waddr[4]]  <= wdat[7:0];
        default: ;
      endcase
    end
  end

  p_tdo_lsb_first_r2: assert property (@(posedge tck) disable iff (!trst_n)
    do_sh |=> tdo == $past(sr[1]));

  p_write_vec_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (do_wr && waddr == 5'd2) |=> vec_catch == $past(wdat[7:0]));

  p_read_latch_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (do_up && !dir_wr) |=> rd_addr == $past(waddr));

  p_idle_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !active |=> $stable(sr) && $stable(rd_addr) && $stable(comms_data) && $stable(dbg_ctrl));

  p_write_keeps_addr_r10: assert property (@(posedge tck) disable iff (!trst_n)
    do_wr |=> $stable(rd_addr));
endmodule

// File: tb/dbg_scan_chain_test.sv
module dbg_scan_chain_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [3:0] VER = 4'd5;

  logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
  logic chain_sel = 1'b0, instr_active = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic [4:0] core_status = '0;
  logic tdo, mon_en;
  logic [5:0] dbg_ctrl, comms_ctrl;
  logic [7:0] vec_catch;
  logic [31:0] comms_data;
  logic [1:0][31:0] wp_addr_val, wp_addr_msk, wp_data_val, wp_data_msk;
  logic [1:0][8:0] wp_ctl_val;
  logic [1:0][7:0] wp_ctl_msk;

  int errors = 0, checks = 0;
  bit done = 0;

  dbg_scan_chain #(.VERSION(VER)) uut (.*);

  always #2 tck = ~tck;

  logic [31:0] m_reg [32];
  logic [37:0] m_sr;
  logic [4:0]  m_rd;

  function automatic logic [31:0] width_mask(int a);
    int k = a % 8;
    if (a == 0 || a == 4) return 32'h3f;
    if (a == 2) return 32'hff;
    if (a == 5) return 32'hffffffff;
    if ((a >= 8 && a < 14) || (a >= 16 && a < 22))
      return (k < 4) ? 32'hffffffff : (k == 4) ? 32'h1ff : 32'hff;
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 1) return {27'd0, core_status};
    if (a == 4) return {VER, 22'd0, m_reg[4][5:0]};
    return m_reg[a] & width_mask(a);
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      m_sr = '0;
      m_rd = '0;
    end else if (chain_sel && instr_active) begin
      if (capture_dr) m_sr = {6'd0, m_read(int'(m_rd))};
      else if (shift_dr) m_sr = {tdi, m_sr[37:1]};
      else if (update_dr) begin
        if (m_sr[37]) begin
          if (m_sr[36:32] != 5'd1)
            m_reg[m_sr[36:32]] = m_sr[31:0] & width_mask(int'(m_sr[36:32]));
        end else m_rd = m_sr[36:32];
      end
    end
  end

  always @(negedge tck) if (trst_n) begin
    logic [342:0] act, exp;
    act = {mon_en, dbg_ctrl, vec_catch, comms_ctrl, comms_data, wp_addr_val, wp_addr_msk,
           wp_data_val, wp_data_msk, wp_ctl_val, wp_ctl_msk};
    exp = {m_reg[0][4], m_reg[0][5:0], m_reg[2][7:0], m_reg[4][5:0], m_reg[5],
           m_reg[16], m_reg[8], m_reg[17], m_reg[9], m_reg[18], m_reg[10], m_reg[19], m_reg[11],
           m_reg[20][8:0], m_reg[12][8:0], m_reg[21][7:0], m_reg[13][7:0]};
    checks++;
    if (tdo !== m_sr[0] || act !== exp) begin
      errors++;
      $display("FAIL R2 cycle compare: tdo=%b exp=%b ports=%h exp=%h", tdo, m_sr[0], act, exp);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic c, logic s, logic u, logic d, output logic o);
    @(negedge tck);
    #1;
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
    o = tdo;
  endtask

  task automatic scan(logic dir, logic [4:0] a, logic [31:0] d,
                      output logic [31:0] cap, output logic [5:0] hi);
    logic [37:0] w, o;
    logic x;
    w = {dir, a, d};
    step(1, 0, 0, 0, x);
    for (int i = 0; i < 38; i++) step(0, 1, 0, w[i], o[i]);
    step(0, 0, 1, 0, x);
    step(0, 0, 0, 0, x);
    cap = o[31:0];
    hi = o[37:32];
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    logic [31:0] c;
    logic [5:0] h;
    scan(0, a, 0, c, h);
    scan(0, 5'd0, 0, v, h);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    logic [31:0] c;
    logic [5:0] h;
    scan(1, a, d, c, h);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] c, v;
    logic [5:0] h;
    #10;
    check("R1 reset ports", {mon_en, tdo, dbg_ctrl, vec_catch, comms_ctrl}, 0);
    check("R1 reset wp", wp_addr_val[0] | wp_ctl_val[1], 0);
    @(negedge tck); trst_n = 1'b1; chain_sel = 1'b1; instr_active = 1'b1;

    scan(0, 5'd8, 0, c, h);
    check("R1 first capture reads reg 0", c, 0);
    check("R4 capture clears upper bits", {26'd0, h}, 0);
    scan(1, 5'd8, 32'hDEADBEEF, c, h);
    check("R4 capture of pending 8 before write", c, 0);
    check("R3 wp0 address value write", wp_addr_val[0], 32'hDEADBEEF);
    scan(1, 5'd5, 32'hCAFEF00D, c, h);
    check("R10 pending read survives write", c, 32'hDEADBEEF);
    check("R3 comms data write", comms_data, 32'hCAFEF00D);
    rd(5'd5, v);
    check("R2 lsb-first readback", v, 32'hCAFEF00D);

    wr(5'd0, 32'hFFFFFFFF);
    check("R6 control width", {26'd0, dbg_ctrl}, 32'h3f);
    check("R8 monitor enable set", {31'd0, mon_en}, 1);
    wr(5'd0, 32'hFFFFFFEF);
    check("R8 monitor enable clear", {31'd0, mon_en}, 0);
    rd(5'd0, v);
    check("R5 control readback", v, 32'h2f);

    wr(5'd4, 32'hFFFFFFFF);
    check("R6 comms ctrl width", {26'd0, comms_ctrl}, 32'h3f);
    rd(5'd4, v);
    check("R7 version field", v, {VER, 22'd0, 6'h3f});

    core_status = 5'h15;
    wr(5'd1, 32'hFFFFFFFF);
    rd(5'd1, v);
    check("R6 status read-only", v, 32'h15);
    wr(5'd3, 32'hFFFFFFFF);
    rd(5'd3, v);
    check("R6 unmapped 3 reads zero", v, 0);
    wr(5'd30, 32'h12345678);
    rd(5'd30, v);
    check("R6 unmapped 30 reads zero", v, 0);

    wr(5'd20, 32'hFFFFFFFF);
    wr(5'd21, 32'hFFFFFFFF);
    check("R5 wp1 control value width", {23'd0, wp_ctl_val[1]}, 32'h1ff);
    check("R5 wp1 control mask width", {24'd0, wp_ctl_msk[1]}, 32'hff);
    rd(5'd20, v);
    check("R5 wp1 control value read", v, 32'h1ff);
    wr(5'd11, 32'h0F0F0F0F);
    check("R5 wp0 data mask", wp_data_msk[0], 32'h0F0F0F0F);
    wr(5'd2, 32'h000001A5);
    check("R5 vector catch width", {24'd0, vec_catch}, 32'hA5);

    chain_sel = 1'b0;
    wr(5'd2, 32'h33);
    check("R9 deselected chain", {24'd0, vec_catch}, 32'hA5);
    chain_sel = 1'b1; instr_active = 1'b0;
    wr(5'd2, 32'h44);
    check("R9 instruction inactive", {24'd0, vec_catch}, 32'hA5);
    instr_active = 1'b1;

    rd(5'd2, v);
    check("R4 two-scan read", v, 32'hA5);

    @(negedge tck); trst_n = 1'b0;
    #1;
    check("R1 async reset clears", {mon_en, dbg_ctrl, vec_catch, comms_data[16:0]}, 0);
    @(negedge tck); trst_n = 1'b1;
    scan(0, 5'd0, 0, c, h);
    check("R1 pending address cleared", c, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule